// File: doc/BRIEF.md
# Edge-Triggered Input Capture Channel

This block timestamps events on an external pin. It runs a free-running 16-bit time base. When a selected edge event occurs on the pin, the block copies the time base into a capture buffer and raises a one-clock interrupt pulse. The pin is asynchronous, so it passes through a synchronizer before edge detection. A mode field chooses the event: every rising edge, every falling edge, or every 4th or 16th rising edge, counted by a prescaler. Software can load the time base at any time. As an option, the time base can restart from zero right after each capture, so that the buffer holds the interval between events.

A small controller tracks whether the channel is off, armed for the first capture after a mode write, or running. It has three states:

- `ST_OFF`: the mode code is inactive.
- `ST_ARMED`: a new active mode was written and no capture has happened since.
- `ST_RUN`: at least one capture has happened in the current mode.

The transitions are:

- off-to-armed: an active mode is written.
- off-to-run: an active mode is written and a capture happens in the same cycle.
- armed-to-run: the first qualifying edge arrives.
- run-to-armed: a different active mode is written.
- any-to-off: the mode becomes inactive.

While the channel is armed, the first qualifying edge always captures, whatever the prescaler count is.

Top module: `icap_channel`

## Requirements
- R1: A synchronous reset sets the capture buffer, the interrupt, the time base and the prescaler count to zero, and puts the controller in `ST_OFF`. After reset is released, the time base counts from zero on the first clock edge.
- R2: A pin edge is captured on the third rising clock edge after the pin changes. That edge loads the buffer with the time base value it produces on that same edge (the incremented value). The interrupt is high for exactly the one cycle in which the new buffer value appears. The buffer does not change in any other cycle.
- R3: Mode code 0001 captures on every rising edge and ignores falling edges. Mode code 0010 captures on every falling edge and ignores rising edges.
- R4: Mode code 0011 captures on every 4th rising edge and mode code 0100 on every 16th. The prescaler advances on every synchronized rising edge while the channel is active. A capture fires on a rising edge that finds the count at 3 modulo 4 (code 0011) or at 15 (code 0100).
- R5: Mode code 0000, and every code from 0101 to 1111, disables the channel. A disabled channel makes no capture and no interrupt, and its prescaler count is held at zero.
- R6: The first qualifying edge after an active mode is written always captures. This holds both when entering from a disabled code and when switching between active codes.
- R7: A direct change from one active code to another keeps the prescaler count, so the first paced capture in the new code can come early.
- R8: With clear-on-capture set, the time base becomes zero on the clock edge after the capture edge and then counts on. With it clear, the time base keeps counting through captures.
- R9: A time base write loads the write data on that edge and overrides counting and clearing. A write on the capture edge also cancels the clear that would follow. The buffer still takes the counting value.
- R10: The time base increments by one per clock while the run input is high, wrapping from 0xFFFF to 0x0000. It holds while the run input is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_pin | input | 1 | Asynchronous capture pin |
| cap_mode | input | 4 | Event select code; 0000 and 0101 to 1111 disable the channel |
| clr_on_cap | input | 1 | Clear the time base on the cycle after each capture |
| tb_run | input | 1 | Time base count enable |
| tb_wr | input | 1 | Time base write strobe |
| tb_wdata | input | TB_W | Time base write data |
| cap_buf | output | TB_W | Captured time base value |
| cap_irq | output | 1 | One-cycle pulse marking a new capture |

## Verification
The prescaler count and the armed flag are hidden, so a fault in either appears at the ports only as a capture in the wrong place. An extra interrupt, a missing interrupt, or a paced capture at the wrong edge shows on the third clock after the pin edge that should or should not qualify. A time base that fails to clear, or clears when a write should win, changes the next captured value by a known amount. An unsynchronized or mistimed path shifts every buffer value by a fixed number of counts, so it shows on the first capture.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // Event-select codes for the capture mode field
    typedef enum logic [3:0] {
        MODE_OFF     = 4'd0,
        MODE_RISE    = 4'd1,
        MODE_FALL    = 4'd2,
        MODE_RISE_LO = 4'd3,
        MODE_RISE_HI = 4'd4
    } cap_mode_e;

    // Channel controller states
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } chan_state_e;

    // Only codes 1 through 4 enable the channel
    function automatic logic mode_is_active(input logic [3:0] code);
        return (code >= 4'd1) && (code <= 4'd4);
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain_q;
    logic              hist_q;
    logic              pin_s;

    // Synchronizer chain, one flop per stage
    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign pin_s = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= pin_s;
    end

    assign rise = pin_s & ~hist_q;
    assign fall = ~pin_s & hist_q;

endmodule

// File: rtl/icap_prescale.sv
module icap_prescale #(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 16,
    localparam int CNT_W = $clog2(DIV_HI)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic             hit_lo,
    output logic             hit_hi,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LO_MASK = CNT_W'(DIV_LO - 1);
    localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(DIV_HI - 1);

    logic [CNT_W-1:0] cnt_q;

    // Clearing has priority; stepping wraps naturally at DIV_HI
    always_ff @(posedge clk) begin
        if (rst || clear) cnt_q <= '0;
        else if (step)    cnt_q <= cnt_q + 1'b1;
    end

    assign hit_lo = (cnt_q & LO_MASK) == LO_MASK;
    assign hit_hi = cnt_q == HI_LAST;
    assign cnt    = cnt_q;

endmodule

// File: rtl/icap_timebase.sv
module icap_timebase #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] tb,
    output logic [W-1:0] tb_inc
);

    logic [W-1:0] tb_q;

    // Counting value: what the time base becomes when nothing overrides it
    assign tb_inc = run ? tb_q + 1'b1 : tb_q;

    // Write wins over clear, clear wins over counting
    always_ff @(posedge clk) begin
        if (rst)      tb_q <= '0;
        else if (wr)  tb_q <= wdata;
        else if (clr) tb_q <= '0;
        else          tb_q <= tb_inc;
    end

    assign tb = tb_q;

endmodule

// File: rtl/icap_ctrl.sv
module icap_ctrl
    import icap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] mode,
    input  logic       rise,
    input  logic       fall,
    input  logic       hit_lo,
    input  logic       hit_hi,
    input  logic       clr_en,
    input  logic       tb_wr,
    output logic       capture,
    output logic       psc_clear,
    output logic       irq,
    output logic       clr_pend
);

    chan_state_e state_q, state_d;
    logic [3:0]  mode_q;
    logic        active;
    logic        changed;
    logic        first;
    logic        any_edge;
    logic        paced_edge;

    assign active  = mode_is_active(mode);
    assign changed = mode != mode_q;
    // Armed, or a mode written this very cycle: the first edge captures
    assign first   = (state_q != ST_RUN) || changed;

    // Edge qualification per mode
    always_comb begin
        any_edge   = 1'b0;
        paced_edge = 1'b0;
        case (mode)
            MODE_RISE: begin
                any_edge   = rise;
                paced_edge = rise;
            end
            MODE_FALL: begin
                any_edge   = fall;
                paced_edge = fall;
            end
            MODE_RISE_LO: begin
                any_edge   = rise;
                paced_edge = rise & hit_lo;
            end
            MODE_RISE_HI: begin
                any_edge   = rise;
                paced_edge = rise & hit_hi;
            end
            default: begin
                any_edge   = 1'b0;
                paced_edge = 1'b0;
            end
        endcase
    end

    assign capture   = active && (first ? any_edge : paced_edge);
    assign psc_clear = !active;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (active) state_d = capture ? ST_RUN : ST_ARMED;
            end
            ST_ARMED: begin
                if (!active)     state_d = ST_OFF;
                else if (capture) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!active)      state_d = ST_OFF;
                else if (capture) state_d = ST_RUN;
                else if (changed) state_d = ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            mode_q  <= 4'd0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    // Output register process
    always_ff @(posedge clk) begin
        if (rst) begin
            irq      <= 1'b0;
            clr_pend <= 1'b0;
        end else begin
            irq      <= capture;
            clr_pend <= capture && clr_en && !tb_wr;
        end
    end

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
    parameter int TB_W        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LO      = 4,
    parameter int DIV_HI      = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap_pin,
    input  logic [3:0]      cap_mode,
    input  logic            clr_on_cap,
    input  logic            tb_run,
    input  logic            tb_wr,
    input  logic [TB_W-1:0] tb_wdata,
    output logic [TB_W-1:0] cap_buf,
    output logic            cap_irq
);

    localparam int PSC_W = $clog2(DIV_HI);

    logic             rise, fall;
    logic             hit_lo, hit_hi;
    logic [PSC_W-1:0] psc_cnt;
    logic             capture, psc_clear, clr_pend;
    logic [TB_W-1:0]  tb_q, tb_inc;
    logic [TB_W-1:0]  buf_q;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (cap_pin),
        .rise      (rise),
        .fall      (fall)
    );

    icap_prescale #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .clear  (psc_clear),
        .step   (rise),
        .hit_lo (hit_lo),
        .hit_hi (hit_hi),
        .cnt    (psc_cnt)
    );

    icap_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (cap_mode),
        .rise      (rise),
        .fall      (fall),
        .hit_lo    (hit_lo),
        .hit_hi    (hit_hi),
        .clr_en    (clr_on_cap),
        .tb_wr     (tb_wr),
        .capture   (capture),
        .psc_clear (psc_clear),
        .irq       (cap_irq),
        .clr_pend  (clr_pend)
    );

    icap_timebase #(.W(TB_W)) u_tb (
        .clk    (clk),
        .rst    (rst),
        .run    (tb_run),
        .wr     (tb_wr),
        .wdata  (tb_wdata),
        .clr    (clr_pend),
        .tb     (tb_q),
        .tb_inc (tb_inc)
    );

    // Capture buffer takes the counting value of the capture edge
    always_ff @(posedge clk) begin
        if (rst)          buf_q <= '0;
        else if (capture) buf_q <= tb_inc;
    end

    assign cap_buf = buf_q;

endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk
    import icap_pkg::*;
#(
    parameter int TB_W  = 16,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       cap_mode,
    input logic             cap_irq,
    input logic [TB_W-1:0]  cap_buf,
    input logic             tb_wr,
    input logic [TB_W-1:0]  tb_wdata,
    input logic             tb_run,
    input logic [TB_W-1:0]  tb_q,
    input logic             clr_pend,
    input logic [CNT_W-1:0] psc_cnt
);

    // R2: buffer moves only in an interrupt cycle
    p_buf_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_irq |-> $stable(cap_buf));

    // R5: an inactive code in the previous cycle yields no interrupt
    p_off_silent_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_is_active($past(cap_mode)) |-> !cap_irq);

    // R5: prescaler emptied while disabled
    p_psc_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_is_active(cap_mode) |=> (psc_cnt == '0));

    // R8: pending clear zeroes the time base unless a write lands
    p_clear_after_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_pend && !tb_wr) |=> (tb_q == '0));

    // R9: write data always lands
    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
        tb_wr |=> (tb_q == $past(tb_wdata)));

    // R10: plain counting with wrap
    p_count_r10: assert property (@(posedge clk) disable iff (rst)
        (!tb_wr && !clr_pend && tb_run) |=> (tb_q == $past(tb_q) + 1'b1));

    // R10: hold while stopped
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!tb_wr && !clr_pend && !tb_run) |=> $stable(tb_q));

endmodule

bind icap_channel icap_channel_chk #(.TB_W(TB_W), .CNT_W(PSC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cap_mode (cap_mode),
    .cap_irq  (cap_irq),
    .cap_buf  (cap_buf),
    .tb_wr    (tb_wr),
    .tb_wdata (tb_wdata),
    .tb_run   (tb_run),
    .tb_q     (tb_q),
    .clr_pend (clr_pend),
    .psc_cnt  (psc_cnt)
);

// File: tb/icap_channel_tb.sv
`timescale 1ns/1ps
module icap_channel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_pin = 1'b0;
    logic [3:0]  cap_mode = 4'd0;
    logic        clr_on_cap = 1'b0;
    logic        tb_run = 1'b1;
    logic        tb_wr = 1'b0;
    logic [15:0] tb_wdata = 16'h0;
    logic [15:0] cap_buf;
    logic        cap_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    icap_channel #(.TB_W(16)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cap_pin    (cap_pin),
        .cap_mode   (cap_mode),
        .clr_on_cap (clr_on_cap),
        .tb_run     (tb_run),
        .tb_wr      (tb_wr),
        .tb_wdata   (tb_wdata),
        .cap_buf    (cap_buf),
        .cap_irq    (cap_irq)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic        pin;
        logic [15:0] wval;
        logic        irq;
        logic [15:0] bufv;
    } vec_t;

    // Each step: write wval, move the pin, expect capture of wval+3
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd1, 1'b1, 16'h0100, 1'b1, 16'h0103},  // R6 first rise, R2
        '{4'd1, 1'b0, 16'h0200, 1'b0, 16'h0103},  // R3 fall ignored
        '{4'd1, 1'b1, 16'h0300, 1'b1, 16'h0303},  // R3 rise
        '{4'd2, 1'b0, 16'h0400, 1'b1, 16'h0403},  // R3 fall
        '{4'd2, 1'b1, 16'h0500, 1'b0, 16'h0403},  // R3 rise ignored
        '{4'd2, 1'b0, 16'h0600, 1'b1, 16'h0603},
        '{4'd0, 1'b1, 16'h0700, 1'b0, 16'h0603},  // R5 off
        '{4'd0, 1'b0, 16'h0800, 1'b0, 16'h0603},
        '{4'd3, 1'b1, 16'h0900, 1'b1, 16'h0903},  // R6 first in /4
        '{4'd3, 1'b0, 16'h0A00, 1'b0, 16'h0903},
        '{4'd3, 1'b1, 16'h0B00, 1'b0, 16'h0903},  // R4
        '{4'd3, 1'b0, 16'h0C00, 1'b0, 16'h0903},
        '{4'd3, 1'b1, 16'h0D00, 1'b0, 16'h0903},
        '{4'd3, 1'b0, 16'h0E00, 1'b0, 16'h0903},
        '{4'd3, 1'b1, 16'h0F00, 1'b1, 16'h0F03},  // R4 4th rise, R5 cleared
        '{4'd5, 1'b0, 16'h1000, 1'b0, 16'h0F03},  // R5 unused code
        '{4'd5, 1'b1, 16'h1100, 1'b0, 16'h0F03}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edge_to(input logic lvl);
        cap_pin = lvl;
        repeat (3) tick();
    endtask

    task automatic settle(input logic [3:0] m);
        cap_mode = m;
        cap_pin  = 1'b0;
        repeat (5) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int k;
        bit found;
        repeat (3) tick();
        check("R1 buffer", cap_buf, 16'h0);
        check("R1 irq", cap_irq, 1'b0);
        rst = 1'b0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            cap_mode = VEC[v].mode;
            tb_wr    = 1'b1;
            tb_wdata = VEC[v].wval;
            tick();
            tb_wr = 1'b0;
            edge_to(VEC[v].pin);
            check($sformatf("R2/R3/R4/R5 vec %0d irq", v), cap_irq, VEC[v].irq);
            check($sformatf("R2/R3/R4/R5 vec %0d buf", v), cap_buf, VEC[v].bufv);
        end

        // R8 clear on capture, R2 pulse width
        settle(4'd1);
        clr_on_cap = 1'b1;
        tb_wr = 1'b1; tb_wdata = 16'h2000;
        tick();
        tb_wr = 1'b0;
        edge_to(1'b1);
        check("R8 capture", cap_buf, 16'h2003);
        cap_pin = 1'b0;
        tick();
        check("R2 single pulse", cap_irq, 1'b0);
        edge_to(1'b1);
        check("R8 interval after clear", cap_buf, 16'h0003);

        // R9 write on capture edge cancels clear
        settle(4'd1);
        tb_wr = 1'b1; tb_wdata = 16'h3000;
        tick();
        tb_wr = 1'b0;
        cap_pin = 1'b1;
        repeat (2) tick();
        tb_wr = 1'b1; tb_wdata = 16'h5000;
        tick();
        tb_wr = 1'b0;
        check("R9 buffer keeps counting value", cap_buf, 16'h3003);
        cap_pin = 1'b0;
        tick();
        edge_to(1'b1);
        check("R9 clear cancelled", cap_buf, 16'h5004);
        clr_on_cap = 1'b0;

        // R10 wrap
        settle(4'd1);
        tb_wr = 1'b1; tb_wdata = 16'hFFFD;
        tick();
        tb_wr = 1'b0;
        edge_to(1'b1);
        check("R10 wrap", cap_buf, 16'h0000);

        // R10 hold when stopped
        settle(4'd1);
        tb_run = 1'b0;
        tb_wr = 1'b1; tb_wdata = 16'h4444;
        tick();
        tb_wr = 1'b0;
        edge_to(1'b1);
        check("R10 hold", cap_buf, 16'h4444);
        tb_run = 1'b1;

        // R6 / R7 mode change keeps prescaler
        settle(4'd0);
        cap_mode = 4'd3;
        tick();
        edge_to(1'b1);
        check("R6 first capture /4", cap_irq, 1'b1);
        edge_to(1'b0); edge_to(1'b1);
        check("R4 no capture count 1", cap_irq, 1'b0);
        edge_to(1'b0); edge_to(1'b1);
        check("R4 no capture count 2", cap_irq, 1'b0);
        edge_to(1'b0);
        cap_mode = 4'd4;
        tick();
        edge_to(1'b1);
        check("R6 first capture after change", cap_irq, 1'b1);
        k = 0;
        found = 1'b0;
        for (int i = 1; i <= 20 && !found; i++) begin
            edge_to(1'b0);
            edge_to(1'b1);
            if (cap_irq) begin
                k = i;
                found = 1'b1;
            end
        end
        check("R7 rises to paced capture", k, 12);

        // R1 mid-run reset
        rst = 1'b1;
        cap_mode = 4'd1;
        cap_pin = 1'b0;
        repeat (3) tick();
        check("R1 buffer after reset", cap_buf, 16'h0);
        check("R1 irq after reset", cap_irq, 1'b0);
        rst = 1'b0;
        cap_pin = 1'b1;
        repeat (3) tick();
        check("R1 time base restarts", cap_buf, 16'h0003);
        check("R1 capture after reset", cap_irq, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule